// File: doc/BRIEF.md
# Instruction Fetch Trace Decoder

This block is a passive monitor. It watches a processor's active-low fetch trace line together with the bus strobes. From them it rebuilds what happens inside the processor's instruction prefetch queue. The trace line carries two meanings, told apart by pulse width:

- one clock low means an ordinary word fetch;
- two clocks low means the pipeline was flushed and a refill has started.

On the fastest bus two indications can run together without a gap. For that reason the decoder does not time pulses. It takes exactly two samples, on the two rising clock edges that follow the strobe's falling edge.

Every decoded event gives a one-clock strobe and the 16-bit word captured from the data bus. Events feed a three-stage model of the queue. Stage A buffers the incoming word, stage B holds the word under initial decode, and stage C holds the opcode under residual decode. A separate pipe-advance input shifts the model down by one stage. Inconsistent traffic raises a sticky protocol-error flag. Privilege level plays no part: every fetch is reported in the same way.

Top module: `fetch_trace_decoder`

## Requirements
- R1: A synchronous reset (`rst` high) empties all three stages, clears the error flag, the event strobes and the captured word, and makes the sampler wait for a strobe falling edge.
- R2: The reference strobe is `as_n` when `show_cycle` is 0 and `ds_n` when `show_cycle` is 1. A falling edge is a rising clock edge that sees the selected strobe low after it was high on the previous edge.
- R3: If `ifetch_n` is low on the falling-edge clock and high on the next clock, this is a fetch. `fetch_stb` is high for one cycle right after that second edge, and `word_out` holds the `data_in` value sampled on it.
- R4: If `ifetch_n` is low on both sample edges, this is a flush. It is reported on `flush_stb` with the same timing and word capture as a fetch.
- R5: On a two-clock bus, `ifetch_n` low for three clocks across two strobes decodes as a flush for the first bus cycle, then a fetch for the second.
- R6: If `ifetch_n` is high on the falling-edge clock, no event is produced for that bus cycle.
- R7: A flush clears all stages and loads the captured word into stage A, so `stage_vld` = 3'b001 and `level` = 1.
- R8: A fetch loads stage A when it is empty. If stage A is full, the fetch sets `proto_err` and stage A keeps its word.
- R9: Each clock with `pipe_adv` high moves C←B and B←A and leaves stage A empty. An advance while both A and B are empty sets `proto_err`.
- R10: When an advance and a fetch fall on the same edge, the advance is applied first. When an advance and a flush fall on the same edge, the flush wins and the advance is ignored.
- R11: `proto_err` stays set until reset.
- R12: `fetch_stb` and `flush_stb` are never high together, and neither is high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ifetch_n | input | 1 | Fetch trace line, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| show_cycle | input | 1 | Selects the data strobe as reference |
| pipe_adv | input | 1 | Pipe-advance pulse, one clock high per advance |
| data_in | input | 16 | Data bus |
| fetch_stb | output | 1 | Ordinary fetch decoded |
| flush_stb | output | 1 | Flush with refill decoded |
| word_out | output | 16 | Word captured with the last event |
| stage_a | output | 16 | Stage A word |
| stage_b | output | 16 | Stage B word |
| stage_c | output | 16 | Stage C word |
| stage_vld | output | 3 | Stage valid bits: bit 0 is A, bit 1 is B, bit 2 is C |
| level | output | 2 | Number of occupied stages |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The assertions assume that the selected strobe stays low on the edge after its falling edge, or returns high there. They also assume that successive bus cycles are at least two clocks apart. Under those conditions a new falling edge can never land on the second sample edge. The stimulus builds every bus cycle from two- or three-clock templates that meet these conditions. The templates change `show_cycle` only while both strobes are high. `pipe_adv` is driven as isolated one-clock pulses, including pulses placed exactly on a decision edge, so that the ordering rules are exercised.

// File: rtl/ftd_pkg.sv
package ftd_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_FETCH = 2'd1,
    EV_FLUSH = 2'd2
  } trace_ev_e;

  typedef enum logic {
    SMP_IDLE   = 1'b0,
    SMP_SECOND = 1'b1
  } smp_state_e;

  // Two active-high samples of the trace line -> event kind.
  function automatic trace_ev_e classify(input logic first_low, input logic second_low);
    if (first_low && second_low)       return EV_FLUSH;
    else if (first_low && !second_low) return EV_FETCH;
    else                               return EV_NONE;
  endfunction

  // Occupancy: number of set bits in a 3-bit valid vector.
  function automatic logic [1:0] occupancy3(input logic [2:0] v);
    logic [1:0] n;
    n = 2'd0;
    for (int i = 0; i < 3; i++) n = n + {1'b0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/ftd_strobe_sel.sv
module ftd_strobe_sel (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic ds_n,
  input  logic show_cycle,
  output logic strb_fall
);
  logic strb_sel;
  logic strb_q;

  assign strb_sel  = show_cycle ? ds_n : as_n;
  assign strb_fall = strb_q && !strb_sel;

  always_ff @(posedge clk) begin
    if (rst) strb_q <= 1'b1;
    else     strb_q <= strb_sel;
  end

  // R2: a detected fall needs a high level between, so two falls never touch
  a_r2_fall_isolated: assert property (@(posedge clk) disable iff (rst)
    strb_fall |=> !strb_fall);

endmodule

// File: rtl/ftd_sampler.sv
module ftd_sampler
  import ftd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb_fall,
  input  logic              ifetch_n,
  input  logic [WORD_W-1:0] data_in,
  output logic              fetch_now,
  output logic              flush_now,
  output logic              fetch_stb,
  output logic              flush_stb,
  output logic [WORD_W-1:0] word_q
);
  smp_state_e state;
  logic       first_low;
  trace_ev_e  decoded;

  assign decoded   = (state == SMP_SECOND) ? classify(first_low, !ifetch_n) : EV_NONE;
  assign fetch_now = (decoded == EV_FETCH);
  assign flush_now = (decoded == EV_FLUSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SMP_IDLE;
      first_low <= 1'b0;
      fetch_stb <= 1'b0;
      flush_stb <= 1'b0;
      word_q    <= '0;
    end else begin
      fetch_stb <= fetch_now;
      flush_stb <= flush_now;
      if (fetch_now || flush_now) word_q <= data_in;
      case (state)
        SMP_IDLE: if (strb_fall) begin
          state     <= SMP_SECOND;
          first_low <= !ifetch_n;
        end
        default: state <= SMP_IDLE;
      endcase
    end
  end

  // R12: events are exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_stb, flush_stb}));
  // R12: no event on two consecutive cycles
  a_r12_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (fetch_stb || flush_stb) |=> !(fetch_stb || flush_stb));
  // R3: every strobe traces back to a fall two edges earlier
  a_r3_event_after_fall: assert property (@(posedge clk) disable iff (rst)
    (fetch_stb || flush_stb) |-> $past(strb_fall, 2));
  // R2: no fall can arrive on the second sample edge
  a_r2_no_fall_in_second: assert property (@(posedge clk) disable iff (rst)
    (state == SMP_SECOND) |-> !strb_fall);

endmodule

// File: rtl/ftd_pipe_model.sv
module ftd_pipe_model #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fetch_now,
  input  logic                    flush_now,
  input  logic                    adv,
  input  logic [WORD_W-1:0]       word_in,
  output logic [DEPTH-1:0]        vld,
  output logic [DEPTH*WORD_W-1:0] words_flat,
  output logic                    err
);
  logic [WORD_W-1:0] words   [DEPTH];
  logic [WORD_W-1:0] n_words [DEPTH];
  logic [DEPTH-1:0]  n_vld;
  logic              n_err;
  logic              adv_fault;
  logic              fetch_fault;

  assign adv_fault = adv && !flush_now && !vld[0] && !vld[1];

  always_comb begin
    n_vld       = vld;
    n_err       = err;
    fetch_fault = 1'b0;
    for (int i = 0; i < DEPTH; i++) n_words[i] = words[i];
    if (flush_now) begin
      n_vld      = '0;
      n_vld[0]   = 1'b1;
      n_words[0] = word_in;
    end else begin
      if (adv) begin
        for (int i = DEPTH-1; i > 0; i--) begin
          n_vld[i]   = vld[i-1];
          n_words[i] = words[i-1];
        end
        n_vld[0] = 1'b0;
      end
      if (fetch_now) begin
        if (n_vld[0]) fetch_fault = 1'b1;
        else begin
          n_vld[0]   = 1'b1;
          n_words[0] = word_in;
        end
      end
    end
    if (adv_fault || fetch_fault) n_err = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else begin
      vld <= n_vld;
      err <= n_err;
      for (int i = 0; i < DEPTH; i++) words[i] <= n_words[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign words_flat[g*WORD_W +: WORD_W] = words[g];
  end

  // R7: flush leaves only stage A occupied
  a_r7_flush_single: assert property (@(posedge clk) disable iff (rst)
    flush_now |=> (vld == DEPTH'(1)));
  // R11: error flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R9: advance without a load empties stage A
  a_r9_adv_empties_a: assert property (@(posedge clk) disable iff (rst)
    (adv && !flush_now && !fetch_now) |=> !vld[0]);
  // R9: advance carries stage B into stage C
  a_r9_adv_moves_b: assert property (@(posedge clk) disable iff (rst)
    (adv && !flush_now && vld[1]) |=> (vld[2] && words[2] == $past(words[1])));
  // R8: fetch into full A keeps A's word
  a_r8_full_a_kept: assert property (@(posedge clk) disable iff (rst)
    (fetch_now && !adv && !flush_now && vld[0]) |=> (err && words[0] == $past(words[0])));

endmodule

// File: rtl/fetch_trace_decoder.sv
module fetch_trace_decoder
  import ftd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ifetch_n,
  input  logic        as_n,
  input  logic        ds_n,
  input  logic        show_cycle,
  input  logic        pipe_adv,
  input  logic [15:0] data_in,
  output logic        fetch_stb,
  output logic        flush_stb,
  output logic [15:0] word_out,
  output logic [15:0] stage_a,
  output logic [15:0] stage_b,
  output logic [15:0] stage_c,
  output logic [2:0]  stage_vld,
  output logic [1:0]  level,
  output logic        proto_err
);
  localparam int WORD_W = 16;
  localparam int DEPTH  = 3;

  logic                    strb_fall;
  logic                    fetch_now;
  logic                    flush_now;
  logic [DEPTH*WORD_W-1:0] words_flat;

  ftd_strobe_sel u_strobe (
    .clk        (clk),
    .rst        (rst),
    .as_n       (as_n),
    .ds_n       (ds_n),
    .show_cycle (show_cycle),
    .strb_fall  (strb_fall)
  );

  ftd_sampler #(.WORD_W(WORD_W)) u_sampler (
    .clk       (clk),
    .rst       (rst),
    .strb_fall (strb_fall),
    .ifetch_n  (ifetch_n),
    .data_in   (data_in),
    .fetch_now (fetch_now),
    .flush_now (flush_now),
    .fetch_stb (fetch_stb),
    .flush_stb (flush_stb),
    .word_q    (word_out)
  );

  ftd_pipe_model #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_pipe (
    .clk        (clk),
    .rst        (rst),
    .fetch_now  (fetch_now),
    .flush_now  (flush_now),
    .adv        (pipe_adv),
    .word_in    (data_in),
    .vld        (stage_vld),
    .words_flat (words_flat),
    .err        (proto_err)
  );

  assign stage_a = words_flat[0*WORD_W +: WORD_W];
  assign stage_b = words_flat[1*WORD_W +: WORD_W];
  assign stage_c = words_flat[2*WORD_W +: WORD_W];
  assign level   = occupancy3(stage_vld);

  // R7: a flush strobe is seen together with a single-stage queue
  a_r7_flush_level: assert property (@(posedge clk) disable iff (rst)
    flush_stb |-> (level == 2'd1 && stage_a == word_out));

endmodule

// File: tb/fetch_trace_decoder_bench.sv
module fetch_trace_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ifetch_n = 1'b1, as_n = 1'b1, ds_n = 1'b1, show_cycle = 1'b0, pipe_adv = 1'b0;
  logic [15:0] data_in = '0;
  logic        fetch_stb, flush_stb, proto_err;
  logic [15:0] word_out, stage_a, stage_b, stage_c;
  logic [2:0]  stage_vld;
  logic [1:0]  level;

  fetch_trace_decoder u_fetch_trace_decoder (
    .clk(clk), .rst(rst), .ifetch_n(ifetch_n), .as_n(as_n), .ds_n(ds_n),
    .show_cycle(show_cycle), .pipe_adv(pipe_adv), .data_in(data_in),
    .fetch_stb(fetch_stb), .flush_stb(flush_stb), .word_out(word_out),
    .stage_a(stage_a), .stage_b(stage_b), .stage_c(stage_c),
    .stage_vld(stage_vld), .level(level), .proto_err(proto_err)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_prev_strb, m_phase, m_first;
  int m_fetch, m_flush, m_word, m_err;
  int m_stage[3];   // -1 = empty

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prev_strb = 1; m_phase = 0; m_first = 0;
    m_fetch = 0; m_flush = 0; m_word = 0; m_err = 0;
    foreach (m_stage[i]) m_stage[i] = -1;
  endtask

  task automatic model_step();
    int strb, ev;
    strb = show_cycle ? int'(ds_n) : int'(as_n);
    ev = 0;
    if (m_phase == 1) begin
      m_phase = 0;
      if (m_first == 1 && ifetch_n == 1'b0) ev = 2;
      else if (m_first == 1) ev = 1;
    end else if (m_prev_strb == 1 && strb == 0) begin
      m_phase = 1;
      m_first = (ifetch_n == 1'b0) ? 1 : 0;
    end
    m_prev_strb = strb;
    m_fetch = (ev == 1); m_flush = (ev == 2);
    if (ev != 0) m_word = int'(data_in);
    if (ev == 2) begin
      m_stage[0] = int'(data_in); m_stage[1] = -1; m_stage[2] = -1;
    end else begin
      if (pipe_adv) begin
        if (m_stage[0] < 0 && m_stage[1] < 0) m_err = 1;
        m_stage[2] = m_stage[1]; m_stage[1] = m_stage[0]; m_stage[0] = -1;
      end
      if (ev == 1) begin
        if (m_stage[0] >= 0) m_err = 1;
        else m_stage[0] = int'(data_in);
      end
    end
  endtask

  task automatic compare_all();
    int n;
    logic [15:0] act_w [3];
    act_w[0] = stage_a; act_w[1] = stage_b; act_w[2] = stage_c;
    n = 0;
    check(cur_req, "fetch_stb", int'(fetch_stb), m_fetch);
    check(cur_req, "flush_stb", int'(flush_stb), m_flush);
    check(cur_req, "word_out", int'(word_out), m_word);
    check(cur_req, "proto_err", int'(proto_err), m_err);
    for (int i = 0; i < 3; i++) begin
      check(cur_req, "stage valid", int'(stage_vld[i]), (m_stage[i] >= 0) ? 1 : 0);
      if (m_stage[i] >= 0) begin
        n++;
        check(cur_req, "stage word", int'(act_w[i]), m_stage[i]);
      end
    end
    check(cur_req, "level", int'(level), n);
  endtask

  task automatic cyc(bit a, bit d, bit sh, bit fn, bit ad, logic [15:0] dat);
    as_n = a; ds_n = d; show_cycle = sh; ifetch_n = fn; pipe_adv = ad; data_in = dat;
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    #1 compare_all();
    @(negedge clk);
  endtask

  task automatic idle(bit ad);
    cyc(1'b1, 1'b1, show_cycle, 1'b1, ad, data_in);
  endtask

  // three-clock bus cycle; ifetch_n low for nlow clocks; adv2 on the decision edge
  task automatic bus3(bit sh, int nlow, logic [15:0] dat, bit adv2);
    for (int e = 1; e <= 3; e++) begin
      bit st;
      st = (e < 3) ? 1'b0 : 1'b1;
      cyc(sh ? 1'b1 : st, sh ? st : 1'b1, sh, (e <= nlow) ? 1'b0 : 1'b1,
          (e == 2) ? adv2 : 1'b0, dat);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1"; do_reset();
    check("R1", "level after reset", int'(level), 0);
    check("R1", "error after reset", int'(proto_err), 0);

    cur_req = "R9"; idle(1'b1);            // advance into an empty queue
    check("R9", "advance on empty sets error", int'(proto_err), 1);
    cur_req = "R11"; idle(1'b0); idle(1'b0);
    check("R11", "error still set", int'(proto_err), 1);
    cur_req = "R1"; do_reset();
    check("R1", "reset clears error", int'(proto_err), 0);

    cur_req = "R4"; bus3(1'b0, 2, 16'hA001, 1'b0);
    cur_req = "R7"; check("R7", "valid after flush", int'(stage_vld), 1);
    cur_req = "R9"; idle(1'b1);
    check("R9", "A moved to B", int'(stage_b), 16'hA001);
    cur_req = "R3"; bus3(1'b0, 1, 16'hB002, 1'b0);
    cur_req = "R12"; idle(1'b0);
    cur_req = "R9"; idle(1'b1);
    cur_req = "R2"; bus3(1'b1, 1, 16'hC003, 1'b0);
    check("R2", "show-cycle fetch loads A", int'(stage_a), 16'hC003);
    cur_req = "R6"; bus3(1'b0, 0, 16'hD004, 1'b0);
    check("R6", "no event leaves word", int'(word_out), 16'hC003);
    cur_req = "R10"; bus3(1'b0, 1, 16'hE005, 1'b1);   // advance + fetch
    check("R10", "advance first then load", int'(stage_a), 16'hE005);
    bus3(1'b0, 2, 16'hF006, 1'b1);                    // advance + flush
    check("R10", "flush wins over advance", int'(stage_vld), 1);

    cur_req = "R5";                                   // two-clock bus, three low clocks
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1111);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1111);
    check("R5", "flush first", int'(flush_stb), 1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2222);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h2222);
    check("R5", "then fetch", int'(fetch_stb), 1);
    check("R5", "fetched word", int'(word_out), 16'h2222);
    idle(1'b0);

    cur_req = "R8"; bus3(1'b0, 1, 16'h3333, 1'b0);   // A already full
    check("R8", "fetch into full A errors", int'(proto_err), 1);
    check("R8", "A keeps its word", int'(stage_a), 16'h2222);
    cur_req = "R11"; idle(1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule